// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is the command front end of a parallel NOR flash memory, built around a small internal array. Each clock cycle it samples the active-low chip enable, write enable and output enable pins, the hardware reset pin and the byte/word select pin, along with the address and data buses. It decodes multi-cycle unlock sequences into read-array, program, sector or chip erase, autoselect and unlock-bypass operations. It runs each program or erase as a timed embedded operation. While that operation runs, reads return status bits and not array contents.

In word mode the address bus carries a word address in its low bits. In byte mode the bus carries a byte address: bit 0 selects the upper byte when it is 1, and the bits above it form the word address. Command decoding uses the word address and the low data byte in both modes. Program and erase durations, and the window that collects further sectors for an erase, are parameters counted in clock cycles.

Top module: `flash_cmd_top`

## Requirements
- R1: A clock cycle is one command write only when ce_ni=0, we_ni=0 and oe_ni=1. A cycle with oe_ni=0 or ce_ni=1 does not advance any command sequence.
- R2: The four writes AA@555, 55@2AA, A0@555, then data@target start a program. Addresses are word addresses truncated to ADDR_W bits, and commands are data_i[7:0].
- R3: AA@555, 55@2AA, 20@555 enters bypass mode. In bypass mode, A0 followed by data@target programs one location. The write 90 followed by the write 00 leaves bypass mode, after which A0 and data writes no longer program.
- R4: A program stores old AND new, so it can only clear bits.
- R5: With byte_ni=0, addr_i[0]=1 selects the upper byte and addr_i[0]=0 the lower byte. Byte reads return the selected byte on data_o[7:0] with zeros above. A byte program leaves the other byte of the word unchanged.
- R6: AA@555, 55@2AA, 90@555 enters autoselect. Reads then return MFR_ID at word address 0, DEV_ID at word address 1 and 0x00 at other low-address values, all on data_o[7:0] with zeros above.
- R7: While an operation is busy, reads return {8'h00, ~target bit 7, toggle, 6'b0}. The toggle bit inverts after every busy read. Status is returned for exactly PROG_CYC (program) or ERASE_CYC (erase) cycles after the final write, and array data is returned after that.
- R8: AA,55,80,AA,55 then 10@555 erases every word to FFFF. Replacing the final 10@555 with 30 at a sector address selects that sector; each further 30 write adds a sector. The erase starts ERS_WIN write-free cycles after the last 30 write and sets every word of the selected sectors to FFFF. A sector is the top SECT_W bits of the word address.
- R9: Writing F0 from any idle, unlock, autoselect or bypass state returns to read-array mode.
- R10: While rst_ni=0, data_oe_o=0 and all writes are ignored. A program in progress is aborted with the array left unchanged, and the block comes back in read-array mode.
- R11: Raising ce_ni during a program does not stop it.
- R12: Writes made while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low hardware reset, asynchronous |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| byte_ni | input | 1 | 0 selects byte mode, 1 selects word mode |
| addr_i | input | ADDR_W+1 | Word address in low bits, or byte address in byte mode |
| data_i | input | 16 | Write data and command byte |
| data_o | output | 16 | Read data, status or identification code |
| data_oe_o | output | 1 | High while data_o should be driven onto the bus |

## Verification
The read path is combinational, so a read returns its value in the same cycle it is driven. The toggle bit inverts at the clock edge that closes each busy read. A program or erase becomes busy at the edge that captures its final write. It shows status on exactly the next PROG_CYC or ERASE_CYC reads and array data on the read after those. A sector erase starts at the edge ERS_WIN cycles after its last 30 write, so a read in that cycle still returns array data and the read in the following cycle returns status. The bench drives the bus on falling edges, samples 1 ns later and steps reads one per cycle, so every expected status or data value falls in an exactly counted cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PROG,
    ST_E1, ST_E2, ST_E3, ST_ERS_WIN,
    ST_ASEL, ST_BYP, ST_BYP_PROG, ST_BYP_EXIT,
    ST_BUSY
  } cmd_state_e;

  localparam logic [7:0] CMD_KEY_A    = 8'hAA;
  localparam logic [7:0] CMD_KEY_B    = 8'h55;
  localparam logic [7:0] CMD_PROG     = 8'hA0;
  localparam logic [7:0] CMD_ERS_SET  = 8'h80;
  localparam logic [7:0] CMD_ID       = 8'h90;
  localparam logic [7:0] CMD_BYP      = 8'h20;
  localparam logic [7:0] CMD_BACK     = 8'hF0;
  localparam logic [7:0] CMD_SECT     = 8'h30;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_BYP_OUT  = 8'h00;

  localparam logic [11:0] KEY_ADDR_A  = 12'h555;
  localparam logic [11:0] KEY_ADDR_B  = 12'h2AA;

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int SECT_W  = 2,
  parameter int ERS_WIN = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [7:0]               cmd_i,
  input  logic                     done_i,
  output cmd_state_e               state_o,
  output logic                     start_prog_o,
  output logic                     start_erase_o,
  output logic [(1<<SECT_W)-1:0]   erase_mask_o
);

  localparam int NSECT = 1 << SECT_W;
  localparam int WIN_W = $clog2(ERS_WIN + 1);

  cmd_state_e         state_q, state_d;
  logic [NSECT-1:0]   mask_q, mask_d, sect_bit;
  logic [WIN_W-1:0]   win_q, win_d;
  logic               ret_byp_q, ret_byp_d;
  logic               at_a, at_b;
  logic [SECT_W-1:0]  sect;

  assign at_a     = (waddr_i == KEY_ADDR_A[ADDR_W-1:0]);
  assign at_b     = (waddr_i == KEY_ADDR_B[ADDR_W-1:0]);
  assign sect     = waddr_i[ADDR_W-1 -: SECT_W];
  assign sect_bit = NSECT'(1) << sect;

  always_comb begin
    state_d       = state_q;
    mask_d        = mask_q;
    win_d         = win_q;
    ret_byp_d     = ret_byp_q;
    start_prog_o  = 1'b0;
    start_erase_o = 1'b0;
    unique case (state_q)
      ST_READ: if (wr_i && cmd_i == CMD_KEY_A && at_a) state_d = ST_U1;
      ST_U1:   if (wr_i) state_d = (cmd_i == CMD_KEY_B && at_b) ? ST_U2 : ST_READ;
      ST_U2: if (wr_i) begin
        state_d = ST_READ;
        if (at_a) begin
          case (cmd_i)
            CMD_PROG:    state_d = ST_PROG;
            CMD_ERS_SET: state_d = ST_E1;
            CMD_ID:      state_d = ST_ASEL;
            CMD_BYP:     state_d = ST_BYP;
            default:     state_d = ST_READ;
          endcase
        end
      end
      ST_PROG: if (wr_i) begin
        start_prog_o = 1'b1;
        ret_byp_d    = 1'b0;
        state_d      = ST_BUSY;
      end
      ST_E1: if (wr_i) state_d = (cmd_i == CMD_KEY_A && at_a) ? ST_E2 : ST_READ;
      ST_E2: if (wr_i) state_d = (cmd_i == CMD_KEY_B && at_b) ? ST_E3 : ST_READ;
      ST_E3: if (wr_i) begin
        if (cmd_i == CMD_CHIP && at_a) begin
          mask_d        = '1;
          start_erase_o = 1'b1;
          ret_byp_d     = 1'b0;
          state_d       = ST_BUSY;
        end else if (cmd_i == CMD_SECT) begin
          mask_d  = sect_bit;
          win_d   = '0;
          state_d = ST_ERS_WIN;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_ERS_WIN: begin
        if (wr_i) begin
          if (cmd_i == CMD_SECT) begin
            mask_d = mask_q | sect_bit;
            win_d  = '0;
          end else begin
            state_d = ST_READ;
          end
        end else if (win_q == WIN_W'(ERS_WIN - 1)) begin
          start_erase_o = 1'b1;
          ret_byp_d     = 1'b0;
          state_d       = ST_BUSY;
        end else begin
          win_d = win_q + 1'b1;
        end
      end
      ST_ASEL: if (wr_i && cmd_i == CMD_BACK) state_d = ST_READ;
      ST_BYP: if (wr_i) begin
        case (cmd_i)
          CMD_PROG: state_d = ST_BYP_PROG;
          CMD_ID:   state_d = ST_BYP_EXIT;
          CMD_BACK: state_d = ST_READ;
          default:  state_d = ST_BYP;
        endcase
      end
      ST_BYP_PROG: if (wr_i) begin
        start_prog_o = 1'b1;
        ret_byp_d    = 1'b1;
        state_d      = ST_BUSY;
      end
      ST_BYP_EXIT: if (wr_i) begin
        state_d = (cmd_i == CMD_BYP_OUT || cmd_i == CMD_BACK) ? ST_READ : ST_BYP;
      end
      ST_BUSY: if (done_i) state_d = ret_byp_q ? ST_BYP : ST_READ;
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_READ;
      mask_q    <= '0;
      win_q     <= '0;
      ret_byp_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      mask_q    <= mask_d;
      win_q     <= win_d;
      ret_byp_q <= ret_byp_d;
    end
  end

  assign state_o      = state_q;
  assign erase_mask_o = mask_d;

endmodule

// File: rtl/flash_cmd_exec.sv
module flash_cmd_exec #(
  parameter int ADDR_W    = 5,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_prog_i,
  input  logic                    start_erase_i,
  input  logic [(1<<SECT_W)-1:0]  mask_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic                    byte_mode_i,
  input  logic                    byte_hi_i,
  input  logic [15:0]             data_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    erase_o,
  output logic                    poll_o,
  output logic                    commit_prog_o,
  output logic                    commit_erase_o,
  output logic [(1<<SECT_W)-1:0]  mask_o,
  output logic [ADDR_W-1:0]       tgt_addr_o,
  output logic [15:0]             tgt_data_o
);

  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic               busy_q, erase_q, tgt7_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [(1<<SECT_W)-1:0] mask_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [15:0]        data_q, merged;

  // other byte lane all ones so the AND leaves it untouched
  always_comb begin
    if (!byte_mode_i)   merged = data_i;
    else if (byte_hi_i) merged = {data_i[7:0], 8'hFF};
    else                merged = {8'hFF, data_i[7:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      tgt7_q  <= 1'b0;
      cnt_q   <= '0;
      mask_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!busy_q && (start_prog_i || start_erase_i)) begin
      busy_q  <= 1'b1;
      erase_q <= start_erase_i;
      tgt7_q  <= start_erase_i ? 1'b1 : data_i[7];
      cnt_q   <= start_erase_i ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
      mask_q  <= mask_i;
      addr_q  <= waddr_i;
      data_q  <= merged;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o         = busy_q;
  assign done_o         = busy_q && (cnt_q == '0);
  assign erase_o        = erase_q;
  assign poll_o         = ~tgt7_q;
  assign commit_prog_o  = done_o && !erase_q;
  assign commit_erase_o = done_o && erase_q;
  assign mask_o         = mask_q;
  assign tgt_addr_o     = addr_q;
  assign tgt_data_o     = data_q;

endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array #(
  parameter int ADDR_W = 5,
  parameter int SECT_W = 2
) (
  input  logic                    clk_i,
  input  logic                    prog_i,
  input  logic                    erase_i,
  input  logic [(1<<SECT_W)-1:0]  mask_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [15:0]             wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [15:0]             rdata_o
);

  localparam int NWORDS = 1 << ADDR_W;
  localparam int NSECT  = 1 << SECT_W;
  localparam int WPS_W  = ADDR_W - SECT_W;

  logic [15:0]      mem_q [NWORDS];
  logic [NSECT-1:0] sect_clr;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign sect_clr[s] = erase_i & mask_i[s];
  end

  always_ff @(posedge clk_i) begin
    for (int w = 0; w < NWORDS; w++) begin
      if (sect_clr[w >> WPS_W])
        mem_q[w] <= 16'hFFFF;
      else if (prog_i && waddr_i == ADDR_W'(w))
        mem_q[w] <= mem_q[w] & wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/flash_cmd_rdmux.sv
module flash_cmd_rdmux #(
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hB3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        busy_i,
  input  logic        asel_i,
  input  logic        poll_i,
  input  logic        byte_mode_i,
  input  logic        byte_hi_i,
  input  logic [1:0]  id_sel_i,
  input  logic [15:0] arr_i,
  output logic [15:0] data_o
);

  logic       tgl_q;
  logic [7:0] id_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tgl_q <= 1'b0;
    else if (busy_i && rd_i) tgl_q <= ~tgl_q;
  end

  always_comb begin
    case (id_sel_i)
      2'd0:    id_code = MFR_ID;
      2'd1:    id_code = DEV_ID;
      default: id_code = 8'h00;
    endcase
  end

  always_comb begin
    if (busy_i)           data_o = {8'h00, poll_i, tgl_q, 6'b0};
    else if (asel_i)      data_o = {8'h00, id_code};
    else if (!byte_mode_i) data_o = arr_i;
    else if (byte_hi_i)   data_o = {8'h00, arr_i[15:8]};
    else                  data_o = {8'h00, arr_i[7:0]};
  end

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 5,
  parameter int         SECT_W    = 2,
  parameter int         PROG_CYC  = 6,
  parameter int         ERASE_CYC = 20,
  parameter int         ERS_WIN   = 8,
  parameter logic [7:0] MFR_ID    = 8'h5A,
  parameter logic [7:0] DEV_ID    = 8'hB3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              byte_ni,
  input  logic [ADDR_W:0]   addr_i,
  input  logic [15:0]       data_i,
  output logic [15:0]       data_o,
  output logic              data_oe_o
);

  localparam int NSECT = 1 << SECT_W;

  logic              wr, rd, byte_mode, byte_hi;
  logic [ADDR_W-1:0] waddr;
  cmd_state_e        state;
  logic              start_prog, start_erase, busy, done, op_erase, poll;
  logic              commit_prog, commit_erase;
  logic [NSECT-1:0]  dec_mask, ers_mask;
  logic [ADDR_W-1:0] tgt_addr;
  logic [15:0]       tgt_data, arr_rdata;

  assign wr        = !ce_ni && !we_ni && oe_ni;
  assign rd        = !ce_ni && !oe_ni && we_ni;
  assign byte_mode = !byte_ni;
  assign byte_hi   = addr_i[0];
  assign waddr     = byte_mode ? addr_i[ADDR_W:1] : addr_i[ADDR_W-1:0];
  assign data_oe_o = rd && rst_ni;

  flash_cmd_decoder #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .ERS_WIN(ERS_WIN)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .waddr_i(waddr),
    .cmd_i(data_i[7:0]), .done_i(done), .state_o(state),
    .start_prog_o(start_prog), .start_erase_o(start_erase),
    .erase_mask_o(dec_mask)
  );

  flash_cmd_exec #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_exec (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_prog_i(start_prog),
    .start_erase_i(start_erase), .mask_i(dec_mask), .waddr_i(waddr),
    .byte_mode_i(byte_mode), .byte_hi_i(byte_hi), .data_i(data_i),
    .busy_o(busy), .done_o(done), .erase_o(op_erase), .poll_o(poll),
    .commit_prog_o(commit_prog), .commit_erase_o(commit_erase),
    .mask_o(ers_mask), .tgt_addr_o(tgt_addr), .tgt_data_o(tgt_data)
  );

  flash_cmd_array #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W)
  ) u_array (
    .clk_i(clk_i), .prog_i(commit_prog), .erase_i(commit_erase),
    .mask_i(ers_mask), .waddr_i(tgt_addr), .wdata_i(tgt_data),
    .raddr_i(waddr), .rdata_o(arr_rdata)
  );

  flash_cmd_rdmux #(
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rdmux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd), .busy_i(busy),
    .asel_i(state == ST_ASEL), .poll_i(poll), .byte_mode_i(byte_mode),
    .byte_hi_i(byte_hi), .id_sel_i(waddr[1:0]), .arr_i(arr_rdata),
    .data_o(data_o)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_ni,
  input logic        we_ni,
  input logic        oe_ni,
  input logic [15:0] data_i,
  input logic [15:0] data_o,
  input logic        data_oe_o,
  input logic        busy_i,
  input logic        op_erase_i,
  input cmd_state_e  state_i,
  input logic        start_prog_i,
  input logic        start_erase_i
);

  logic        rd, wr, busy_d, erase_d;
  logic [31:0] run_cnt;

  assign rd = !ce_ni && !oe_ni && we_ni;
  assign wr = !ce_ni && !we_ni && oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_d  <= 1'b0;
      erase_d <= 1'b0;
      run_cnt <= '0;
    end else begin
      busy_d  <= busy_i;
      erase_d <= op_erase_i;
      run_cnt <= busy_i ? run_cnt + 1 : '0;
    end
  end

  // R7
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_d && !busy_i) |-> (run_cnt == (erase_d ? 32'(ERASE_CYC) : 32'(PROG_CYC))));

  // R7
  status_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && data_oe_o) |-> (data_o[15:8] == 8'h00 && data_o[5:0] == 6'h00));

  // R7
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd && $past(busy_i && rd)) |-> (data_o[6] != $past(data_o[6])));

  // R12
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_i || start_erase_i) |-> !busy_i);

  // R12
  busy_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BUSY) == busy_i);

  // R3
  byp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BYP_EXIT && wr && data_i[7:0] == 8'h00) |=> (state_i == ST_READ));

  // R10
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!data_oe_o);
    end
  end

endmodule

bind flash_cmd_top flash_cmd_chk #(
  .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
  .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
  .busy_i(busy), .op_erase_i(op_erase), .state_i(state),
  .start_prog_i(start_prog), .start_erase_i(start_erase)
);

// File: tb/tb_flash_cmd_top.sv
module tb_flash_cmd_top;

  localparam int         ADDR_W    = 5;
  localparam int         SECT_W    = 2;
  localparam int         PROG_CYC  = 6;
  localparam int         ERASE_CYC = 20;
  localparam int         ERS_WIN   = 8;
  localparam logic [7:0] MFR_ID    = 8'h5A;
  localparam logic [7:0] DEV_ID    = 8'hB3;
  localparam int         NWORDS    = 1 << ADDR_W;
  localparam int         WPS       = 1 << (ADDR_W - SECT_W);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, byte_ni = 1'b1;
  logic [ADDR_W:0]   addr_i = '0;
  logic [15:0]       data_i = '0;
  logic [15:0]       data_o;
  logic              data_oe_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NWORDS];

  always #10 clk_i = ~clk_i;

  flash_cmd_top #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .ERS_WIN(ERS_WIN), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) dut (.*);

  localparam logic [ADDR_W:0] WA = {1'b0, 5'h15};
  localparam logic [ADDR_W:0] WB = {1'b0, 5'h0A};
  localparam logic [ADDR_W:0] BA = 6'h2A;
  localparam logic [ADDR_W:0] BB = 6'h15;

  function automatic logic [ADDR_W:0] wad(int w);
    return {1'b0, ADDR_W'(w)};
  endfunction

  function automatic logic [15:0] pat(int w);
    return 16'(w * 16'h0913) ^ 16'hC35A;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_raw(logic ce, logic we, logic oe, logic [ADDR_W:0] a, logic [15:0] d);
    ce_ni = ce; we_ni = we; oe_ni = oe; addr_i = a; data_i = d;
    @(negedge clk_i);
    ce_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic bus_wr(logic [ADDR_W:0] a, logic [15:0] d);
    bus_raw(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic bus_rd(logic [ADDR_W:0] a, output logic [15:0] q, output logic oe);
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1; addr_i = a;
    #1;
    q = data_o; oe = data_oe_o;
    @(negedge clk_i);
    ce_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic unlock(logic [7:0] c);
    bus_wr(WA, 16'(CMD_AA));
    bus_wr(WB, 16'h0055);
    bus_wr(WA, {8'h00, c});
  endtask
  localparam logic [7:0] CMD_AA = 8'hAA;

  // reads right after the final write: n status reads, then data
  task automatic watch(string req, logic tgt7, int n, logic [ADDR_W:0] a, logic [15:0] expw);
    logic [15:0] q; logic oe; logic t0;
    t0 = 1'b0;
    for (int k = 0; k < n; k++) begin
      bus_rd(a, q, oe);
      if (k == 0) t0 = q[6];
      chk(req, q, {8'h00, ~tgt7, t0 ^ 1'(k & 1), 6'b0});
    end
    bus_rd(a, q, oe);
    chk(req, q, expw);
  endtask

  task automatic sweep(string req);
    logic [15:0] q; logic oe;
    for (int w = 0; w < NWORDS; w++) begin
      bus_rd(wad(w), q, oe);
      chk(req, q, model[w]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q; logic oe;
    @(negedge clk_i);
    // R10 outputs quiet while reset held, even with a read on the bus
    bus_rd(wad(0), q, oe);
    chk("R10 reset oe", 16'(oe), 16'h0000);
    rst_ni = 1'b1;
    idle(2);
    chk("R10 idle oe", 16'(data_oe_o), 16'h0000);

    // R8 chip erase
    unlock(8'h80);
    bus_wr(WA, 16'h00AA);
    bus_wr(WB, 16'h0055);
    bus_wr(WA, 16'h0010);
    watch("R8 chip erase", 1'b1, ERASE_CYC, wad(0), 16'hFFFF);
    for (int w = 0; w < NWORDS; w++) model[w] = 16'hFFFF;
    sweep("R8 chip erased");

    // R2 standard program, R7 exact status window
    unlock(8'hA0);
    bus_wr(wad(3), 16'hF0F0);
    watch("R2 R7 program", 1'b1, PROG_CYC, wad(3), 16'hF0F0);
    // R4 only clears bits
    unlock(8'hA0);
    bus_wr(wad(3), 16'h0FFF);
    watch("R4 and", 1'b1, PROG_CYC, wad(3), 16'h00F0);
    model[3] = 16'h00F0;

    // R1 writes with oe low or ce high do not advance a sequence
    bus_raw(1'b0, 1'b0, 1'b0, WA, 16'h00AA);
    bus_raw(1'b0, 1'b0, 1'b0, WB, 16'h0055);
    bus_raw(1'b0, 1'b0, 1'b0, WA, 16'h00A0);
    bus_wr(wad(5), 16'h0000);
    bus_raw(1'b1, 1'b0, 1'b1, WA, 16'h00AA);
    bus_raw(1'b1, 1'b0, 1'b1, WB, 16'h0055);
    bus_raw(1'b1, 1'b0, 1'b1, WA, 16'h00A0);
    bus_wr(wad(5), 16'h0000);
    idle(PROG_CYC + 1);
    bus_rd(wad(5), q, oe);
    chk("R1 ignored write", q, 16'hFFFF);

    // R5 byte mode
    byte_ni = 1'b0;
    bus_wr(BA, 16'h00AA);
    bus_wr(BB, 16'h0055);
    bus_wr(BA, 16'h00A0);
    bus_wr({5'd6, 1'b1}, 16'h003C);
    watch("R5 byte prog", 1'b0, PROG_CYC, {5'd6, 1'b1}, 16'h003C);
    bus_rd({5'd6, 1'b0}, q, oe);
    chk("R5 byte low", q, 16'h00FF);
    byte_ni = 1'b1;
    model[6] = 16'h3CFF;
    bus_rd(wad(6), q, oe);
    chk("R5 word view", q, 16'h3CFF);

    // R6 autoselect, R9 F0 exit
    unlock(8'h90);
    bus_rd(wad(0), q, oe);
    chk("R6 mfr", q, {8'h00, MFR_ID});
    bus_rd(wad(1), q, oe);
    chk("R6 dev", q, {8'h00, DEV_ID});
    bus_rd(wad(2), q, oe);
    chk("R6 other", q, 16'h0000);
    bus_wr(wad(0), 16'h00F0);
    bus_rd(wad(3), q, oe);
    chk("R9 asel exit", q, 16'h00F0);

    // R9 F0 mid-sequence and in bypass
    bus_wr(WA, 16'h00AA);
    bus_wr(WB, 16'h0055);
    bus_wr(WA, 16'h00F0);
    bus_wr(wad(7), 16'h0000);
    idle(PROG_CYC + 1);
    bus_rd(wad(7), q, oe);
    chk("R9 abort seq", q, 16'hFFFF);
    unlock(8'h20);
    bus_wr(wad(0), 16'h00F0);
    bus_wr(wad(0), 16'h00A0);
    bus_wr(wad(8), 16'h0000);
    idle(PROG_CYC + 1);
    bus_rd(wad(8), q, oe);
    chk("R9 bypass exit", q, 16'hFFFF);

    // R3 bypass sweep over every word
    unlock(8'h20);
    for (int w = 0; w < NWORDS; w++) begin
      bus_wr(wad(0), 16'h00A0);
      bus_wr(wad(w), pat(w));
      idle(PROG_CYC + 1);
      model[w] = model[w] & pat(w);
    end
    bus_wr(wad(0), 16'h0090);
    bus_wr(wad(0), 16'h0000);
    bus_wr(wad(0), 16'h00A0);
    bus_wr(wad(0), 16'h0000);
    idle(PROG_CYC + 1);
    sweep("R3 bypass");

    // R8 two-sector erase with collection window
    unlock(8'h80);
    bus_wr(WA, 16'h00AA);
    bus_wr(WB, 16'h0055);
    bus_wr(wad(1 * WPS), 16'h0030);
    bus_wr(wad(3 * WPS + 2), 16'h0030);
    idle(ERS_WIN - 1);
    bus_rd(wad(0), q, oe);
    chk("R8 window data", q, model[0]);
    bus_rd(wad(0), q, oe);
    chk("R8 window status", q & 16'hFFBF, 16'h0000);
    idle(ERASE_CYC + 1);
    for (int w = 0; w < NWORDS; w++)
      if ((w / WPS) == 1 || (w / WPS) == 3) model[w] = 16'hFFFF;
    sweep("R8 sectors");

    // R10 reset aborts a program
    unlock(8'hA0);
    bus_wr(wad(9), 16'h1234);
    idle(2);
    rst_ni = 1'b0;
    bus_rd(wad(9), q, oe);
    chk("R10 oe in reset", 16'(oe), 16'h0000);
    bus_wr(wad(9), 16'h0000);
    rst_ni = 1'b1;
    idle(PROG_CYC + 2);
    bus_rd(wad(9), q, oe);
    chk("R10 aborted", q, 16'hFFFF);
    chk("R10 driving", 16'(oe), 16'h0001);

    // R11 program finishes with ce high
    unlock(8'hA0);
    bus_wr(wad(12), 16'h5A5A);
    idle(PROG_CYC + 1);
    bus_rd(wad(12), q, oe);
    chk("R11 ce high", q, 16'h5A5A);

    // R12 writes during busy ignored
    unlock(8'hA0);
    bus_wr(wad(11), 16'hAAAA);
    bus_wr(WA, 16'h00AA);
    bus_wr(WB, 16'h0055);
    bus_wr(WA, 16'h00A0);
    idle(PROG_CYC);
    bus_wr(wad(11), 16'h0000);
    idle(PROG_CYC + 1);
    bus_rd(wad(11), q, oe);
    chk("R12 busy writes", q, 16'hAAAA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule